// File: doc/BRIEF.md
# Rule-Constrained Priority Selector

This block is a small clocked controller that issues one of four selection codes (0, 1, 2, 3) each time it is told to advance. On every advance it looks at two condition inputs, `stress` and `hurry`, and at its own recent selections. It then takes the most preferred code that no rule forbids. Preference runs 1 first, then 0, then 3, then 2. Some rules come from the condition inputs and others from the history of earlier selections.

The state machine's state is the selection now on the output. There are four states: `SEL_0`, `SEL_1`, `SEL_2` and `SEL_3`. Reset enters `SEL_3`. Each transition is taken on a clock edge where `step` is high, and it goes to the state the priority pick names. Any state can move to any other state except itself. The transition into `SEL_1` is blocked while `stress` is high, and also while code 1 is one of the last two selections. The transition into `SEL_0` is blocked while `hurry` is high. When `step` is low, the machine stays in its state.

At most three codes are ever ruled out at once: 1, 0, and the current code. A legal choice therefore always exists. A shift register holds one flag per recent selection, recording whether that selection was code 1. It is cleared by reset, so the selections before reset count as containing no 1.

Top module: `rulepick_top`

## Requirements
- R1: After a synchronous reset, `sel` is 3 and the recent-selection history holds no code 1. The first advance with `stress` and `hurry` low therefore yields 1.
- R2: On a clock edge with `step` low, `sel` keeps its value. The history also stays as it was, so later picks are the same as if the idle cycles had not occurred.
- R3: An advance taken while `stress` is 1 never yields code 1.
- R4: An advance taken while `hurry` is 1 never yields code 0.
- R5: An advance never yields the code that `sel` shows just before it.
- R6: Code 1 never appears twice within any three consecutive selections. After a 1, the next two selections are not 1.
- R7: Each advance yields the first code in the order 1, 0, 3, 2 that R3 to R6 allow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance strobe: make a new selection on this edge |
| stress | input | 1 | Condition that forbids code 1 |
| hurry | input | 1 | Condition that forbids code 0 |
| sel | output | 2 | Registered selection code, 0 to 3 |

## Verification
Every combination of `stress` and `hurry` over four advances from reset is swept, which is 256 sequences. These sweeps reach every reachable pairing of state and recent history, and they separate the repeat rule from the window rule on code 1. A directed sequence first walks the chain 1, 0, 3, 1. That chain separates the case where 1 is barred by a repeat from the case where it is barred by being two selections back. Idle gaps are placed between advances, with the condition inputs toggling during each gap. Finally, a long random run with random strobes confirms that idle cycles change neither the output nor the history.

// File: rtl/rulepick_pkg.sv
package rulepick_pkg;
    localparam int unsigned NUM_SEL = 4;
    localparam int unsigned SEL_W   = $clog2(NUM_SEL);

    typedef enum logic [SEL_W-1:0] {
        SEL_0 = 2'd0,
        SEL_1 = 2'd1,
        SEL_2 = 2'd2,
        SEL_3 = 2'd3
    } sel_e;

    // preference, most wanted first
    localparam sel_e PRIO_ORDER [NUM_SEL] = '{SEL_1, SEL_0, SEL_3, SEL_2};

    localparam sel_e RESET_SEL = SEL_3;
    localparam sel_e STRESS_BAN = SEL_1;
    localparam sel_e HURRY_BAN  = SEL_0;
endpackage

// File: rtl/rulepick_hist.sv
module rulepick_hist #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic new_is_one,
    output logic recent_one
);
    logic [DEPTH-1:0] one_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            one_sr[0] <= 1'b0;
        end else if (adv) begin
            one_sr[0] <= new_is_one;
        end
    end

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    one_sr[g] <= 1'b0;
                end else if (adv) begin
                    one_sr[g] <= one_sr[g-1];
                end
            end
        end
    endgenerate

    assign recent_one = |one_sr;
endmodule

// File: rtl/rulepick_mask.sv
module rulepick_mask
    import rulepick_pkg::*;
(
    input  sel_e               cur,
    input  logic               stress,
    input  logic               hurry,
    input  logic               recent_one,
    output logic [NUM_SEL-1:0] allow
);
    logic [NUM_SEL-1:0] not_cur;

    always_comb begin
        not_cur = '1;
        unique case (cur)
            SEL_0: not_cur[SEL_0] = 1'b0;
            SEL_1: not_cur[SEL_1] = 1'b0;
            SEL_2: not_cur[SEL_2] = 1'b0;
            SEL_3: not_cur[SEL_3] = 1'b0;
        endcase
    end

    always_comb begin
        allow = not_cur;
        if (stress || recent_one) begin
            allow[STRESS_BAN] = 1'b0;
        end
        if (hurry) begin
            allow[HURRY_BAN] = 1'b0;
        end
    end
endmodule

// File: rtl/rulepick_prio.sv
module rulepick_prio
    import rulepick_pkg::*;
(
    input  logic [NUM_SEL-1:0] allow,
    input  sel_e               fallback,
    output sel_e               pick
);
    always_comb begin
        pick = fallback;
        for (int i = NUM_SEL - 1; i >= 0; i--) begin
            if (allow[PRIO_ORDER[i]]) begin
                pick = PRIO_ORDER[i];
            end
        end
    end
endmodule

// File: rtl/rulepick_top.sv
module rulepick_top
    import rulepick_pkg::*;
#(
    parameter int unsigned ONE_WINDOW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             stress,
    input  logic             hurry,
    output logic [SEL_W-1:0] sel
);
    localparam int unsigned HIST_DEPTH = ONE_WINDOW - 1;

    sel_e               state_q;
    sel_e               state_d;
    logic               recent_one;
    logic [NUM_SEL-1:0] allow;

    rulepick_hist #(.DEPTH(HIST_DEPTH)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .adv        (step),
        .new_is_one (state_d == SEL_1),
        .recent_one (recent_one)
    );

    rulepick_mask u_mask (
        .cur        (state_q),
        .stress     (stress),
        .hurry      (hurry),
        .recent_one (recent_one),
        .allow      (allow)
    );

    rulepick_prio u_prio (
        .allow    (allow),
        .fallback (RESET_SEL),
        .pick     (state_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RESET_SEL;
        end else if (step) begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            SEL_0: sel = 2'd0;
            SEL_1: sel = 2'd1;
            SEL_2: sel = 2'd2;
            SEL_3: sel = 2'd3;
        endcase
    end
endmodule

// File: rtl/rulepick_chk.sv
module rulepick_chk (
    input logic       clk,
    input logic       rst,
    input logic       step,
    input logic       stress,
    input logic       hurry,
    input logic [1:0] sel
);
    logic       step_d;
    logic [1:0] ago;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_d <= 1'b0;
            ago    <= 2'd3;
        end else begin
            step_d <= step;
            if (step_d) begin
                ago <= (sel == 2'd1) ? 2'd0 : ((ago == 2'd3) ? 2'd3 : ago + 2'd1);
            end
        end
    end

    AST_RESET_VALUE: assert property (@(posedge clk) rst |=> sel == 2'd3); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !step |=> $stable(sel)); // R2
    AST_STRESS_NO_ONE: assert property (@(posedge clk) disable iff (rst) (step && stress) |=> sel != 2'd1); // R3
    AST_HURRY_NO_ZERO: assert property (@(posedge clk) disable iff (rst) (step && hurry) |=> sel != 2'd0); // R4
    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (rst) step |=> sel != $past(sel)); // R5
    AST_ONE_SPACING: assert property (@(posedge clk) disable iff (rst) (step_d && sel == 2'd1) |-> ago >= 2'd2); // R6
endmodule

bind rulepick_top rulepick_chk u_chk (.*);

// File: tb/sim_rulepick_top.sv
module sim_rulepick_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step = 1'b0;
    logic       stress = 1'b0;
    logic       hurry = 1'b0;
    logic [1:0] sel;

    int n_cmp = 0;
    int n_bad = 0;
    int m_cur = 3;
    bit m_prev_one = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rulepick_top u0 (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .stress (stress),
        .hurry  (hurry),
        .sel    (sel)
    );

    function automatic int ref_pick(int cur, bit ps, bit ph, bit prev_one);
        int order [4] = '{1, 0, 3, 2};
        for (int i = 0; i < 4; i++) begin
            int c = order[i];
            if (c == cur) continue;
            if (c == 1 && (ps || prev_one || cur == 1)) continue;
            if (c == 0 && ph) continue;
            return c;
        end
        return 3;
    endfunction

    task automatic check(string tag, int exp);
        n_cmp++;
        if (int'(sel) != exp) begin
            n_bad++;
            $display("FAIL %s: sel=%0d expected=%0d", tag, sel, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        step = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cur = 3;
        m_prev_one = 1'b0;
        check("R1 reset value", 3);
    endtask

    // called at a negedge; returns at the following negedge
    task automatic cycle(string tag, bit st, bit ps, bit ph);
        step = st;
        stress = ps;
        hurry = ph;
        @(negedge clk);
        if (st) begin
            int nxt = ref_pick(m_cur, ps, ph, m_prev_one);
            m_prev_one = (m_cur == 1);
            m_cur = nxt;
        end
        check(tag, m_cur);
        step = 1'b0;
    endtask

    initial begin
        do_reset();
        // directed walk
        cycle("R1 first pick is 1", 1, 0, 0);
        cycle("R5 no repeat of 1", 1, 0, 0);
        cycle("R6 1 two back barred", 1, 0, 0);
        cycle("R7 1 allowed again", 1, 0, 0);
        for (int k = 0; k < 4; k++) cycle("R2 idle hold", 0, k[0], k[1]);
        cycle("R3 stress bars 1", 1, 1, 0);
        cycle("R4 hurry and stress", 1, 1, 1);
        cycle("R2 idle hold", 0, 1, 1);
        cycle("R7 preferred 1", 1, 0, 1);
        cycle("R4 hurry bars 0", 1, 0, 1);

        // exhaustive four-step sweep from reset
        for (int q = 0; q < 256; q++) begin
            do_reset();
            for (int j = 0; j < 4; j++) begin
                cycle("R7 sweep", 1, q[2*j], q[2*j+1]);
            end
        end

        // random run with idle gaps
        do_reset();
        for (int k = 0; k < 3000; k++) begin
            int rv = $urandom;
            cycle(rv[0] ? "R7 random" : "R2 random idle", rv[0], rv[1], rv[2]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: sel=%0d expected=completion", sel);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule